// File: doc/BRIEF.md
# Consecutive Watchdog Reset Boot Fallback Controller

This controller sits next to the reset logic of a chip. It stops a system from rebooting forever into an image that keeps crashing. Each time the system comes out of a reset, the reset logic pulses `rst_evt` for one cycle and presents the cause of that reset on `rst_cause`.

The controller records whether the latest restart came from a watchdog timeout. It also keeps a saturating count of watchdog restarts that happened back to back. This state lives in registers that only the power-on reset `por_n` clears, so it models storage that survives the system resets it describes.

When the count rises strictly above a programmable threshold, the controller latches `boot_sel` high. The boot logic then loads a fallback or safe-mode image instead of the normal one. Software reports a healthy start with `boot_ok`, which clears the count. It can release the fallback selection with `fb_clr`.

Top module: `boot_fallback_ctrl`

## Requirements
- R1: After `por_n` is released, `wdt_cnt` is 0, `last_wdt` is 0, `boot_sel` is 0 and `thr_q` is 5.
- R2: A cycle with `rst_evt` high and `rst_cause` equal to 2'b00 (watchdog) raises `wdt_cnt` by one and sets `last_wdt` to 1 at the next clock edge.
- R3: `wdt_cnt` saturates at 15 and never wraps to 0 on a further watchdog reset.
- R4: A cycle with `rst_evt` high and any other cause (2'b01 external pin, 2'b10 software request, 2'b11 other) clears `wdt_cnt` and `last_wdt` at the next edge.
- R5: A `boot_ok` pulse clears `wdt_cnt` at the next edge. If `rst_evt` is high in the same cycle, the reset event wins.
- R6: `boot_sel` rises one cycle after `wdt_cnt` becomes strictly greater than `thr_q`. A count equal to the threshold does not select the fallback.
- R7: Once high, `boot_sel` stays high through later reset events and `boot_ok` pulses. Only `fb_clr` or `por_n` clears it. `fb_clr` also clears `wdt_cnt` at the next edge and takes priority over every other input.
- R8: A cycle with `thr_we` high loads `thr_wdata` into `thr_q` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset that clears all retained state |
| rst_evt | input | 1 | One-cycle pulse when a system reset has just ended |
| rst_cause | input | 2 | Cause of that reset: 00 watchdog, 01 pin, 10 software, 11 other |
| boot_ok | input | 1 | Software strobe reporting a successful boot |
| fb_clr | input | 1 | Clears the fallback selection and the count |
| thr_we | input | 1 | Threshold write enable |
| thr_wdata | input | 4 | Threshold write data |
| thr_q | output | 4 | Current threshold |
| wdt_cnt | output | 4 | Consecutive watchdog reset count |
| last_wdt | output | 1 | High when the latest reset came from the watchdog |
| boot_sel | output | 1 | High selects the fallback image |

## Verification
A corrupted count shows at `wdt_cnt` one cycle after the reset event that moved it. It reaches `boot_sel` one cycle later, as a fallback that comes too early or never comes. A lost or spurious latch bit shows on `boot_sel` at the next edge and persists until `fb_clr`, so any later sample exposes it. The sweeps cover every threshold value, so an off-by-one in the strict comparison changes the cycle in which `boot_sel` rises.

// File: rtl/boot_fallback_ctrl.sv
module boot_fallback_ctrl #(
  parameter int CW      = 4,
  parameter int THR_RST = 5
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_evt,
  input  logic [1:0]    rst_cause,
  input  logic          boot_ok,
  input  logic          fb_clr,
  input  logic          thr_we,
  input  logic [CW-1:0] thr_wdata,
  output logic [CW-1:0] thr_q,
  output logic [CW-1:0] wdt_cnt,
  output logic          last_wdt,
  output logic          boot_sel
);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [1:0]    CAUSE_WDT = 2'b00;

  logic is_wdt, at_max, over;
  logic [CW-1:0] cnt_inc;

  assign is_wdt  = (rst_cause == CAUSE_WDT);
  assign at_max  = (wdt_cnt == CNT_MAX);
  assign cnt_inc = at_max ? wdt_cnt : wdt_cnt + 1'b1;
  assign over    = (wdt_cnt > thr_q);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wdt_cnt <= '0;
    end else if (fb_clr) begin
      wdt_cnt <= '0;
    end else if (rst_evt) begin
      wdt_cnt <= is_wdt ? cnt_inc : '0;
    end else if (boot_ok) begin
      wdt_cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       last_wdt <= 1'b0;
    else if (rst_evt) last_wdt <= is_wdt;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      boot_sel <= 1'b0;
    else if (fb_clr) boot_sel <= 1'b0;
    else             boot_sel <= boot_sel | over;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      thr_q <= CW'(THR_RST);
    else if (thr_we) thr_q <= thr_wdata;
  end
endmodule

module boot_fallback_ctrl_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          por_n,
  input logic          rst_evt,
  input logic [1:0]    rst_cause,
  input logic          boot_ok,
  input logic          fb_clr,
  input logic          thr_we,
  input logic [CW-1:0] thr_wdata,
  input logic [CW-1:0] thr_q,
  input logic [CW-1:0] wdt_cnt,
  input logic          last_wdt,
  input logic          boot_sel
);
  localparam logic [CW-1:0] MAXV = '1;

  assert_inc_R2: assert property (@(posedge clk) disable iff (!por_n)
    (rst_evt && rst_cause == 2'b00 && !fb_clr && wdt_cnt != MAXV)
      |=> (wdt_cnt == $past(wdt_cnt) + 1'b1) && last_wdt);

  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!por_n)
    (rst_evt && rst_cause == 2'b00 && !fb_clr && wdt_cnt == MAXV) |=> wdt_cnt == MAXV);

  assert_other_cause_R4: assert property (@(posedge clk) disable iff (!por_n)
    (rst_evt && rst_cause != 2'b00) |=> wdt_cnt == '0 && !last_wdt);

  assert_boot_ok_R5: assert property (@(posedge clk) disable iff (!por_n)
    (boot_ok && !rst_evt) |=> wdt_cnt == '0);

  assert_select_R6: assert property (@(posedge clk) disable iff (!por_n)
    (wdt_cnt > thr_q && !fb_clr) |=> boot_sel);

  assert_latch_R7: assert property (@(posedge clk) disable iff (!por_n)
    (boot_sel && !fb_clr) |=> boot_sel);

  assert_release_R7: assert property (@(posedge clk) disable iff (!por_n)
    fb_clr |=> !boot_sel && wdt_cnt == '0);

  assert_thr_R8: assert property (@(posedge clk) disable iff (!por_n)
    thr_we |=> thr_q == $past(thr_wdata));
endmodule

bind boot_fallback_ctrl boot_fallback_ctrl_chk #(.CW(CW)) chk_i (.*);

// File: tb/boot_fallback_ctrl_tb.sv
module boot_fallback_ctrl_tb_top;
  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic rst_evt = 1'b0, boot_ok = 1'b0, fb_clr = 1'b0, thr_we = 1'b0;
  logic [1:0] rst_cause = 2'b00;
  logic [3:0] thr_wdata = 4'd0;
  logic [3:0] thr_q, wdt_cnt;
  logic last_wdt, boot_sel;

  int total = 0, bad = 0;
  int m_cnt, m_thr, m_last, m_sel;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  boot_fallback_ctrl dut_i (
    .clk(clk), .por_n(por_n), .rst_evt(rst_evt), .rst_cause(rst_cause),
    .boot_ok(boot_ok), .fb_clr(fb_clr), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .thr_q(thr_q), .wdt_cnt(wdt_cnt), .last_wdt(last_wdt), .boot_sel(boot_sel)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "wdt_cnt", int'(wdt_cnt), m_cnt);
    chk(tag, "last_wdt", int'(last_wdt), m_last);
    chk(tag, "boot_sel", int'(boot_sel), m_sel);
    chk(tag, "thr_q", int'(thr_q), m_thr);
  endtask

  task automatic do_por();
    @(negedge clk);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    m_cnt = 0; m_thr = 5; m_last = 0; m_sel = 0;
    check_all("R1");
  endtask

  // one operation cycle, then one idle cycle, then check
  task automatic step(input bit e, input int c, input bit ok, input bit cl,
                      input bit we, input int wd, input string tag);
    int n_sel;
    rst_evt = e; rst_cause = 2'(c); boot_ok = ok; fb_clr = cl;
    thr_we = we; thr_wdata = 4'(wd);
    @(posedge clk);
    n_sel = cl ? 0 : ((m_sel != 0 || m_cnt > m_thr) ? 1 : 0);
    if (cl) m_cnt = 0;
    else if (e) m_cnt = (c == 0) ? ((m_cnt == 15) ? 15 : m_cnt + 1) : 0;
    else if (ok) m_cnt = 0;
    if (e) m_last = (c == 0) ? 1 : 0;
    if (we) m_thr = wd;
    m_sel = n_sel;
    @(negedge clk);
    rst_evt = 1'b0; boot_ok = 1'b0; fb_clr = 1'b0; thr_we = 1'b0;
    @(posedge clk);
    if (m_cnt > m_thr) m_sel = 1;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    do_por();
    // R6 at default threshold: five watchdog resets keep the normal image
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 0, "R2");
    chk("R6", "boot_sel at count equal threshold", int'(boot_sel), 0);
    step(1, 0, 0, 0, 0, 0, "R6");
    chk("R6", "boot_sel above threshold", int'(boot_sel), 1);

    // sweep every threshold value
    for (int t = 0; t < 16; t++) begin
      do_por();
      step(0, 0, 0, 0, 1, t, "R8");
      for (int i = 0; i < 18; i++) step(1, 0, 0, 0, 0, 0, (i >= 15) ? "R3" : "R6");
      chk("R3", "saturated count", int'(wdt_cnt), 15);
      for (int c = 1; c < 4; c++) begin
        step(1, 0, 0, 0, 0, 0, "R2");
        step(1, c, 0, 0, 0, 0, "R4");
      end
      step(1, 0, 0, 0, 0, 0, "R2");
      step(0, 0, 1, 0, 0, 0, "R5");
      step(1, 0, 1, 0, 0, 0, "R5");
      step(1, 0, 0, 1, 0, 0, "R7");
      step(1, 0, 0, 0, 0, 0, "R7");
    end

    // boot_ok before threshold repeatedly prevents fallback
    do_por();
    for (int i = 0; i < 10; i++) begin
      step(1, 0, 0, 0, 0, 0, "R2");
      step(1, 0, 0, 0, 0, 0, "R2");
      step(0, 0, 1, 0, 0, 0, "R5");
    end
    chk("R5", "no fallback with good boots", int'(boot_sel), 0);

    // lowering threshold below the current count selects fallback
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 1, 2, "R8");
    chk("R6", "fallback after threshold lowered", int'(boot_sel), 1);
    step(1, 2, 0, 0, 0, 0, "R7");
    chk("R7", "latched after pin reset", int'(boot_sel), 1);
    do_por();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule